// File: doc/BRIEF.md
# In-Frame Response Request Controller

This block sits next to the receiver of a variable-pulse-width serial vehicle link and decides whether a single-byte in-frame response (IFR) should follow the current frame. It counts the header bytes of each incoming frame, works out from the first byte whether the header is one or three bytes long, and raises a header-complete flag when the last header byte has arrived. Every received byte is also kept in a small frame buffer that software reads at consecutive addresses starting from a fixed offset.

A response can be requested two ways. When a three-byte header asks for a response through its response bit and responses are enabled, the block raises the request on its own. For short headers, software looks at the buffered header and strobes a request. The request is held until end-of-data has been seen on the bus. The stored response byte is then handed to the bit-level transmitter, and no CRC is added. If arbitration is lost, a type-two response configured for retry is sent again, and any other response is dropped. A request that arrives after its response window has closed is refused and reported.

Top module: `ifr_request_ctrl`

## Requirements
- R1: When bit 4 of the first header byte is 1 the header is one byte: `headerDone` is 1 in the cycle after that byte is strobed, and the block raises no request by itself, whatever bit 3 holds.
- R2: When bit 4 of the first header byte is 0 the header is three bytes: `headerDone` stays 0 after the first and second bytes and becomes 1 in the cycle after the third.
- R3: `headerDone` is 0 in the cycle after `eofEvt` or `swRxReset`.
- R4: Reading address 0x50+i returns byte i of the current frame (i from 0). An address below 0x50 or beyond the buffer depth returns 0x00.
- R5: With a three-byte header whose first byte has bit 3 equal to 0, and with the response enable set, `txIfrPending` rises two cycles after the third byte. With bit 3 equal to 1, or with the enable clear, it stays 0.
- R6: A `swTxIfr` strobe that arrives while the window is open (from header completion until the next start-of-frame) sets `txIfrPending` one cycle later, but only while the response enable is set. With the enable clear it is ignored and reports no error.
- R7: `txStart` is a one-cycle pulse. It comes one cycle after `eodEvt` (or one cycle after a request that follows end-of-data) and never earlier. `txByte` then shows the configured response value, which is kept across frames without being rewritten.
- R8: A `txDone` while sending clears `txIfrPending` and gives a one-cycle `ifrDone` with `ifrAbandon` low.
- R9: After `txArbLost`, if the type-two and retry options are both set, `txIfrPending` stays high and `txStart` pulses again two cycles after the loss. Otherwise `txIfrPending` clears and `ifrDone` and `ifrAbandon` pulse together for one cycle.
- R10: A `swTxIfr` strobe after the window has closed (after a start-of-frame, or once the response has finished) leaves `txIfrPending` at 0 and pulses `missedReq` in the next cycle.
- R11: After the synchronous reset, all flags and pulses are 0 and `txByte` is 0x00.
- R12: A start-of-frame that arrives before transmission has begun drops the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxByteValid | input | 1 | Strobe: a received byte is present on rxByte |
| rxByte | input | 8 | Received byte |
| sofEvt | input | 1 | Start-of-frame event |
| eodEvt | input | 1 | End-of-data symbol detected |
| eofEvt | input | 1 | End-of-frame event, frame fully received |
| swRxReset | input | 1 | Software receive-reset strobe |
| cfgWe | input | 1 | Write strobe for the four configuration values |
| cfgIfrValue | input | 8 | Response byte to store |
| cfgIfrEnable | input | 1 | Response enable |
| cfgRetryEnable | input | 1 | Retry after arbitration loss |
| cfgTypeTwo | input | 1 | Response is of type two |
| swTxIfr | input | 1 | Software transmit-request strobe |
| rdAddr | input | 8 | Buffer read address, relative to the module base |
| rdData | output | 8 | Buffer read data (combinational) |
| txArbLost | input | 1 | Transmitter lost arbitration |
| txDone | input | 1 | Transmitter finished the response byte |
| txStart | output | 1 | One-cycle pulse starting the transmitter |
| txByte | output | 8 | Byte handed to the transmitter |
| headerDone | output | 1 | Header-complete flag |
| txIfrPending | output | 1 | Response request outstanding |
| ifrDone | output | 1 | One-cycle pulse, response finished or dropped |
| ifrAbandon | output | 1 | Qualifies ifrDone as a drop |
| missedReq | output | 1 | One-cycle pulse, late software request refused |

## Verification
Inputs are changed at the falling edge and outputs are read at the following falling edge. Flags and pulses that one register produces, such as `headerDone`, `txStart` after end-of-data, `ifrDone`, `missedReq` and a software-requested `txIfrPending`, are checked one cycle after their stimulus. An automatic request passes through two registers, so the check waits a second cycle, and the restart after a lost arbitration is looked for in the second cycle after the loss. The value is also checked one cycle earlier, when it must still be 0. `rdData` is combinational and is checked in the same cycle as the address.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  // Strobes from the sequencing control into the datapath
  typedef struct packed {
    logic loadTx;   // copy the response value into the transmit holding register
    logic dropTx;   // clear the transmit holding register
  } ifrStrobe_t;

  typedef enum logic [0:0] {
    CS_IDLE = 1'b0,
    CS_SEND = 1'b1
  } ctlState_t;
endpackage

// File: rtl/ifr_datapath.sv
module ifr_datapath #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int BUF_DEPTH = 12,
  parameter int BUF_BASE = 'h50,
  parameter int FMT_BIT  = 4,
  parameter int KBIT     = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rxByteValid,
  input  logic [DATA_W-1:0]   rxByte,
  input  logic                sofEvt,
  input  logic                eofEvt,
  input  logic                swRxReset,
  input  logic                cfgWe,
  input  logic [DATA_W-1:0]   cfgIfrValue,
  input  logic                cfgIfrEnable,
  input  logic                cfgRetryEnable,
  input  logic                cfgTypeTwo,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  input  ifr_pkg::ifrStrobe_t strobes,
  output logic [DATA_W-1:0]   txByte,
  output logic                headerDone,
  output logic                hdrComplete,
  output logic                hdrAuto,
  output logic                ifrEnable,
  output logic                retryEnable,
  output logic                typeTwo
);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(BUF_DEPTH);
  localparam logic [CNT_W-1:0]  LAST3    = CNT_W'(2);
  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BUF_BASE);

  logic [CNT_W-1:0]  byteCnt;
  logic              lenIs3;
  logic              kAsked;
  logic [DATA_W-1:0] ifrValue;
  logic [DATA_W-1:0] bufMem [BUF_DEPTH];
  logic              wrByte;

  assign wrByte = rxByteValid && !swRxReset && !sofEvt && (byteCnt < CNT_MAX);

  // Configuration registers, kept across frames
  always_ff @(posedge clk) begin
    if (rst) begin
      ifrValue    <= '0;
      ifrEnable   <= 1'b0;
      retryEnable <= 1'b0;
      typeTwo     <= 1'b0;
    end else if (cfgWe) begin
      ifrValue    <= cfgIfrValue;
      ifrEnable   <= cfgIfrEnable;
      retryEnable <= cfgRetryEnable;
      typeTwo     <= cfgTypeTwo;
    end
  end

  // Byte counter and header tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      byteCnt     <= '0;
      lenIs3      <= 1'b0;
      kAsked      <= 1'b0;
      headerDone  <= 1'b0;
      hdrComplete <= 1'b0;
      hdrAuto     <= 1'b0;
    end else begin
      hdrComplete <= 1'b0;
      hdrAuto     <= 1'b0;
      if (swRxReset || sofEvt) begin
        byteCnt    <= '0;
        headerDone <= 1'b0;
      end else if (eofEvt) begin
        headerDone <= 1'b0;
      end else if (wrByte) begin
        byteCnt <= byteCnt + 1'b1;
        if (byteCnt == '0) begin
          lenIs3 <= !rxByte[FMT_BIT];
          kAsked <= !rxByte[KBIT];
          if (rxByte[FMT_BIT] && !headerDone) begin
            headerDone  <= 1'b1;
            hdrComplete <= 1'b1;
          end
        end else if (byteCnt == LAST3 && lenIs3 && !headerDone) begin
          headerDone  <= 1'b1;
          hdrComplete <= 1'b1;
          hdrAuto     <= kAsked;
        end
      end
    end
  end

  // Frame buffer, one register per slot
  for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        bufMem[g] <= '0;
      end else if (wrByte && byteCnt == CNT_W'(g)) begin
        bufMem[g] <= rxByte;
      end
    end
  end

  // Read port relative to the buffer base
  always_comb begin
    logic [ADDR_W-1:0] rel;
    rel    = rdAddr - BASE_A;
    rdData = '0;
    if (rdAddr >= BASE_A) begin
      for (int i = 0; i < BUF_DEPTH; i++) begin
        if (rel == ADDR_W'(i)) rdData = bufMem[i];
      end
    end
  end

  // Transmit holding register
  always_ff @(posedge clk) begin
    if (rst) begin
      txByte <= '0;
    end else if (strobes.loadTx) begin
      txByte <= ifrValue;
    end else if (strobes.dropTx) begin
      txByte <= '0;
    end
  end
endmodule

// File: rtl/ifr_control.sv
module ifr_control (
  input  logic                clk,
  input  logic                rst,
  input  logic                sofEvt,
  input  logic                eodEvt,
  input  logic                swRxReset,
  input  logic                swTxIfr,
  input  logic                hdrComplete,
  input  logic                hdrAuto,
  input  logic                ifrEnable,
  input  logic                retryEnable,
  input  logic                typeTwo,
  input  logic                txArbLost,
  input  logic                txDone,
  output ifr_pkg::ifrStrobe_t strobes,
  output logic                txStart,
  output logic                txIfrPending,
  output logic                ifrDone,
  output logic                ifrAbandon,
  output logic                missedReq
);
  import ifr_pkg::*;

  ctlState_t state;
  logic windowOpen;
  logic eodSeen;
  logic windowNow;
  logic startCond;
  logic sendOk;
  logic sendLost;
  logic retryOk;
  logic frameStart;

  assign frameStart = sofEvt || swRxReset;
  assign windowNow  = (windowOpen || hdrComplete) && !frameStart;
  assign startCond  = (state == CS_IDLE) && txIfrPending && (eodSeen || eodEvt) && !frameStart;
  assign sendOk     = (state == CS_SEND) && txDone;
  assign sendLost   = (state == CS_SEND) && !txDone && txArbLost;
  assign retryOk    = typeTwo && retryEnable;

  always_comb begin
    strobes.loadTx = startCond;
    strobes.dropTx = sendOk || (sendLost && !retryOk);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= CS_IDLE;
      windowOpen   <= 1'b0;
      eodSeen      <= 1'b0;
      txStart      <= 1'b0;
      txIfrPending <= 1'b0;
      ifrDone      <= 1'b0;
      ifrAbandon   <= 1'b0;
      missedReq    <= 1'b0;
    end else begin
      txStart    <= 1'b0;
      ifrDone    <= 1'b0;
      ifrAbandon <= 1'b0;
      missedReq  <= 1'b0;

      // end-of-data tracking per frame
      if (frameStart)   eodSeen <= 1'b0;
      else if (eodEvt)  eodSeen <= 1'b1;

      // response window
      if (frameStart)       windowOpen <= 1'b0;
      else if (hdrComplete) windowOpen <= 1'b1;

      // request sources
      if (state == CS_IDLE && frameStart) begin
        txIfrPending <= 1'b0;
      end else if (hdrComplete && hdrAuto && ifrEnable) begin
        txIfrPending <= 1'b1;
      end

      if (swTxIfr) begin
        if (!windowNow) begin
          missedReq <= 1'b1;
        end else if (ifrEnable && state == CS_IDLE) begin
          txIfrPending <= 1'b1;
        end
      end

      // sequencing
      unique case (state)
        CS_IDLE: begin
          if (startCond) begin
            txStart <= 1'b1;
            state   <= CS_SEND;
          end
        end
        CS_SEND: begin
          if (sendOk) begin
            state        <= CS_IDLE;
            txIfrPending <= 1'b0;
            ifrDone      <= 1'b1;
            windowOpen   <= 1'b0;
          end else if (sendLost) begin
            state <= CS_IDLE;
            if (!retryOk) begin
              txIfrPending <= 1'b0;
              ifrDone      <= 1'b1;
              ifrAbandon   <= 1'b1;
              windowOpen   <= 1'b0;
            end
          end
        end
        default: state <= CS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ifr_request_ctrl.sv
module ifr_request_ctrl #(
  parameter int BUF_DEPTH = 12,
  parameter int BUF_BASE  = 'h50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxByteValid,
  input  logic [7:0] rxByte,
  input  logic       sofEvt,
  input  logic       eodEvt,
  input  logic       eofEvt,
  input  logic       swRxReset,
  input  logic       cfgWe,
  input  logic [7:0] cfgIfrValue,
  input  logic       cfgIfrEnable,
  input  logic       cfgRetryEnable,
  input  logic       cfgTypeTwo,
  input  logic       swTxIfr,
  input  logic [7:0] rdAddr,
  output logic [7:0] rdData,
  input  logic       txArbLost,
  input  logic       txDone,
  output logic       txStart,
  output logic [7:0] txByte,
  output logic       headerDone,
  output logic       txIfrPending,
  output logic       ifrDone,
  output logic       ifrAbandon,
  output logic       missedReq
);
  ifr_pkg::ifrStrobe_t strobes;
  logic hdrComplete;
  logic hdrAuto;
  logic ifrEnable;
  logic retryEnable;
  logic typeTwo;

  ifr_datapath #(
    .DATA_W(8), .ADDR_W(8), .BUF_DEPTH(BUF_DEPTH), .BUF_BASE(BUF_BASE),
    .FMT_BIT(4), .KBIT(3)
  ) u_dp (
    .clk(clk), .rst(rst),
    .rxByteValid(rxByteValid), .rxByte(rxByte),
    .sofEvt(sofEvt), .eofEvt(eofEvt), .swRxReset(swRxReset),
    .cfgWe(cfgWe), .cfgIfrValue(cfgIfrValue), .cfgIfrEnable(cfgIfrEnable),
    .cfgRetryEnable(cfgRetryEnable), .cfgTypeTwo(cfgTypeTwo),
    .rdAddr(rdAddr), .rdData(rdData),
    .strobes(strobes), .txByte(txByte),
    .headerDone(headerDone), .hdrComplete(hdrComplete), .hdrAuto(hdrAuto),
    .ifrEnable(ifrEnable), .retryEnable(retryEnable), .typeTwo(typeTwo)
  );

  ifr_control u_ctl (
    .clk(clk), .rst(rst),
    .sofEvt(sofEvt), .eodEvt(eodEvt), .swRxReset(swRxReset), .swTxIfr(swTxIfr),
    .hdrComplete(hdrComplete), .hdrAuto(hdrAuto),
    .ifrEnable(ifrEnable), .retryEnable(retryEnable), .typeTwo(typeTwo),
    .txArbLost(txArbLost), .txDone(txDone),
    .strobes(strobes), .txStart(txStart), .txIfrPending(txIfrPending),
    .ifrDone(ifrDone), .ifrAbandon(ifrAbandon), .missedReq(missedReq)
  );
endmodule

// File: rtl/ifr_request_chk.sv
module ifr_request_chk (
  input logic clk,
  input logic rst,
  input logic rxByteValid,
  input logic eofEvt,
  input logic swRxReset,
  input logic txStart,
  input logic headerDone,
  input logic txIfrPending,
  input logic ifrDone,
  input logic ifrAbandon
);
  // R2
  header_from_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(headerDone) |-> $past(rxByteValid));

  // R3
  header_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (eofEvt || swRxReset) |=> !headerDone);

  // R7
  start_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
    txStart |-> txIfrPending);

  // R7
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    txStart |=> !txStart);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    ifrDone |=> !ifrDone);

  // R8
  done_clears_request_chk: assert property (@(posedge clk) disable iff (rst)
    ifrDone |-> !txIfrPending);

  // R9
  abandon_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    ifrAbandon |-> ifrDone);
endmodule

bind ifr_request_ctrl ifr_request_chk u_chk (
  .clk(clk), .rst(rst), .rxByteValid(rxByteValid), .eofEvt(eofEvt),
  .swRxReset(swRxReset), .txStart(txStart), .headerDone(headerDone),
  .txIfrPending(txIfrPending), .ifrDone(ifrDone), .ifrAbandon(ifrAbandon)
);

// File: tb/tb_ifr_request_ctrl.sv
module tb_ifr_request_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxByteValid = 0, sofEvt = 0, eodEvt = 0, eofEvt = 0, swRxReset = 0;
  logic cfgWe = 0, cfgIfrEnable = 0, cfgRetryEnable = 0, cfgTypeTwo = 0, swTxIfr = 0;
  logic txArbLost = 0, txDone = 0;
  logic [7:0] rxByte = 0, cfgIfrValue = 0, rdAddr = 0;
  logic [7:0] rdData, txByte;
  logic txStart, headerDone, txIfrPending, ifrDone, ifrAbandon, missedReq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifr_request_ctrl dut (
    .clk(clk), .rst(rst), .rxByteValid(rxByteValid), .rxByte(rxByte),
    .sofEvt(sofEvt), .eodEvt(eodEvt), .eofEvt(eofEvt), .swRxReset(swRxReset),
    .cfgWe(cfgWe), .cfgIfrValue(cfgIfrValue), .cfgIfrEnable(cfgIfrEnable),
    .cfgRetryEnable(cfgRetryEnable), .cfgTypeTwo(cfgTypeTwo), .swTxIfr(swTxIfr),
    .rdAddr(rdAddr), .rdData(rdData), .txArbLost(txArbLost), .txDone(txDone),
    .txStart(txStart), .txByte(txByte), .headerDone(headerDone),
    .txIfrPending(txIfrPending), .ifrDone(ifrDone), .ifrAbandon(ifrAbandon),
    .missedReq(missedReq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cfg(input logic [7:0] v, input logic en, input logic rty, input logic t2);
    cfgWe = 1; cfgIfrValue = v; cfgIfrEnable = en; cfgRetryEnable = rty; cfgTypeTwo = t2;
    tick();
    cfgWe = 0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxByteValid = 1; rxByte = b;
    tick();
    rxByteValid = 0;
  endtask

  task automatic pSof();  sofEvt = 1;    tick(); sofEvt = 0;    endtask
  task automatic pEod();  eodEvt = 1;    tick(); eodEvt = 0;    endtask
  task automatic pEof();  eofEvt = 1;    tick(); eofEvt = 0;    endtask
  task automatic pSw();   swTxIfr = 1;   tick(); swTxIfr = 0;   endtask
  task automatic pDone(); txDone = 1;    tick(); txDone = 0;    endtask
  task automatic pLost(); txArbLost = 1; tick(); txArbLost = 0; endtask
  task automatic pRxRst(); swRxReset = 1; tick(); swRxReset = 0; endtask

  task automatic testReset();
    chk("R11 headerDone", headerDone, 0);
    chk("R11 pending", txIfrPending, 0);
    chk("R11 txStart", txStart, 0);
    chk("R11 txByte", txByte, 8'h00);
    chk("R11 ifrDone", ifrDone, 0);
    chk("R11 missedReq", missedReq, 0);
  endtask

  task automatic testShortHeader();
    cfg(8'hA5, 1, 0, 0);
    pSof();
    sendByte(8'h10);
    chk("R1 headerDone one-byte", headerDone, 1);
    tick();
    chk("R1 no auto request", txIfrPending, 0);
    rdAddr = 8'h50; #1;
    chk("R4 read base", rdData, 8'h10);
    rdAddr = 8'h4F; #1;
    chk("R4 below base", rdData, 8'h00);
    pEof();
    chk("R3 eof clears", headerDone, 0);
  endtask

  task automatic testAutoSuccess();
    pSof();
    sendByte(8'h00);
    chk("R2 after byte 1", headerDone, 0);
    sendByte(8'h22);
    chk("R2 after byte 2", headerDone, 0);
    sendByte(8'h33);
    chk("R2 after byte 3", headerDone, 1);
    chk("R5 not yet pending", txIfrPending, 0);
    tick();
    chk("R5 auto pending", txIfrPending, 1);
    tick();
    chk("R7 no start before eod", txStart, 0);
    rdAddr = 8'h52; #1;
    chk("R4 third byte", rdData, 8'h33);
    rdAddr = 8'h5C; #1;
    chk("R4 beyond depth", rdData, 8'h00);
    pEod();
    chk("R7 start after eod", txStart, 1);
    chk("R7 txByte", txByte, 8'hA5);
    tick();
    chk("R7 start one cycle", txStart, 0);
    pDone();
    chk("R8 done pulse", ifrDone, 1);
    chk("R8 not abandon", ifrAbandon, 0);
    chk("R8 pending cleared", txIfrPending, 0);
    tick();
    chk("R8 done one cycle", ifrDone, 0);
    pEof();
  endtask

  task automatic testNoAuto();
    pSof();
    sendByte(8'h08); sendByte(8'h01); sendByte(8'h02);
    tick();
    chk("R5 k bit clear no request", txIfrPending, 0);
    pEof();
    cfg(8'hA5, 0, 0, 0);
    pSof();
    sendByte(8'h00); sendByte(8'h01); sendByte(8'h02);
    tick();
    chk("R5 disabled no request", txIfrPending, 0);
    pEof();
  endtask

  task automatic testSwAbandon();
    cfg(8'hA5, 1, 0, 0);
    pSof();
    sendByte(8'h10);
    pSw();
    chk("R6 sw request accepted", txIfrPending, 1);
    chk("R6 no missed", missedReq, 0);
    pEod();
    chk("R7 start on sw request", txStart, 1);
    chk("R7 value persists", txByte, 8'hA5);
    tick();
    pLost();
    chk("R9 abandon done", ifrDone, 1);
    chk("R9 abandon flag", ifrAbandon, 1);
    chk("R9 abandon clears", txIfrPending, 0);
    pSw();
    chk("R10 late after done missed", missedReq, 1);
    chk("R10 late ignored", txIfrPending, 0);
    pEof();
  endtask

  task automatic testRetry();
    cfg(8'h5A, 1, 1, 1);
    pSof();
    sendByte(8'h00); sendByte(8'h11); sendByte(8'h22);
    tick();
    pEod();
    chk("R7 start", txStart, 1);
    chk("R7 new value", txByte, 8'h5A);
    tick();
    pLost();
    chk("R9 retry no done", ifrDone, 0);
    chk("R9 retry keeps pending", txIfrPending, 1);
    chk("R9 retry not yet", txStart, 0);
    tick();
    chk("R9 retry start", txStart, 1);
    tick();
    pDone();
    chk("R8 done after retry", ifrDone, 1);
    pEof();
  endtask

  task automatic testSofDrop();
    cfg(8'h5A, 1, 0, 0);
    pSof();
    sendByte(8'h10);
    pSw();
    chk("R6 pending before sof", txIfrPending, 1);
    pSof();
    chk("R12 sof drops request", txIfrPending, 0);
    pEod();
    chk("R12 no start after drop", txStart, 0);
    pSw();
    chk("R10 after sof missed", missedReq, 1);
    chk("R10 after sof ignored", txIfrPending, 0);
    pEof();
  endtask

  task automatic testSwDisabledAndRxReset();
    cfg(8'h5A, 0, 0, 0);
    pSof();
    sendByte(8'h10);
    pSw();
    chk("R6 disabled ignored", txIfrPending, 0);
    chk("R6 disabled no error", missedReq, 0);
    chk("R3 header set", headerDone, 1);
    pRxRst();
    chk("R3 rx reset clears", headerDone, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    testReset();
    testShortHeader();
    testAutoSuccess();
    testNoAuto();
    testSwAbandon();
    testRetry();
    testSofDrop();
    testSwDisabledAndRxReset();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule